// File: doc/BRIEF.md
# Load/Store Alignment and Byte-Lane Unit

This unit sits between a processor core and a data memory that is one 64-bit doubleword wide. For each load or store request it adds a sign-extended 16-bit displacement to a base register value to form the byte address. It then checks that address against the access size and steers bytes between the register operand and the eight memory byte lanes. The byte ordering, little-endian or big-endian, can be chosen on each request.

On the memory side the unit drives a doubleword-aligned address, an enable, a write strobe, eight byte enables and the store data in the same cycle as the request. The core side gets a registered response one clock later. That response carries the right-justified and extended load data, a destination-write flag, a misalignment trap flag and the faulting address. A misaligned access does not reach memory and writes no register. The unit never splits a misaligned access into smaller ones.

Top module: `lsu_align_top`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to the address width. `mem_addr` is that address with its three low bits cleared.
- R2: `req_size` is encoded as 0 byte, 1 halfword, 2 word, 3 doubleword. An access is misaligned when the effective address is not a multiple of its size. A halfword traps on address bit 0, a word on bits 1:0, a doubleword on bits 2:0. A byte access never traps.
- R3: A misaligned valid request drives `mem_be` to zero and holds `mem_en` and `mem_we` low. One cycle later it raises `rsp_trap`, keeps `rsp_wen` low and puts the effective address on `rsp_fault_addr`. `rsp_fault_addr` is zero when there is no trap.
- R4: When `req_big_endian` is 0, the byte at doubleword offset k uses lane k (bits 8k+7:8k). A multi-byte value puts its least significant byte at the lowest address.
- R5: When `req_big_endian` is 1, the byte at doubleword offset k uses lane 7-k. A multi-byte value puts its most significant byte at the lowest address.
- R6: A load returns its value right-justified in `rsp_data`. When `req_signed` is 1 the upper bits copy the value's top bit. When it is 0 they are zero. `rsp_wen` is 1 only for an aligned load.
- R7: A store places the low 1, 2, 4 or 8 bytes of `req_wdata` on every lane it writes. It sets one `mem_be` bit per written byte, and those bits are contiguous (a word store sets exactly four). `mem_we` is 1 only for an aligned store.
- R8: `rsp_valid` is `req_valid` delayed by exactly one clock, and each response belongs to the request of the previous cycle.
- R9: A synchronous active-high `rst` clears `rsp_valid`, `rsp_trap`, `rsp_wen`, `rsp_data` and `rsp_fault_addr`.
- R10: The ordering select is taken with each request. Back-to-back requests with different orderings are each steered by their own select, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend load result |
| req_big_endian | input | 1 | Byte ordering for this request |
| req_base | input | ADDR_W | Base register value |
| req_disp | input | DISP_W | Signed displacement |
| req_wdata | input | 64 | Store operand, right-justified |
| mem_rdata | input | 64 | Memory doubleword read this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Doubleword-aligned address |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Store data on lanes |
| rsp_valid | output | 1 | Registered response valid |
| rsp_trap | output | 1 | Misalignment trap |
| rsp_wen | output | 1 | Destination register write |
| rsp_data | output | 64 | Extended load data |
| rsp_fault_addr | output | ADDR_W | Faulting effective address |

## Verification
Lane steering and the alignment trap can act on the same request. A misaligned store or load still has steering logic that would produce enables and lane data, and the trap has to suppress them. The bench provokes this with halfword, word and doubleword requests whose base and negative displacement sum to an odd or partially aligned address, under both orderings. It judges the result by checking in the request cycle that `mem_be`, `mem_en` and `mem_we` are all zero, then checking one cycle later that `rsp_trap` is set, `rsp_wen` is clear and `rsp_fault_addr` holds the sum it computed itself. A second overlap is an ordering change between two back-to-back requests. Each response there is compared against the ordering that came with its own request.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int LANES  = 8;
    localparam int DATA_W = 8 * LANES;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    // Registered response carried from the request stage to the outputs
    typedef struct packed {
        logic              valid;
        logic              trap;
        logic              wen;
        logic [DATA_W-1:0] data;
    } rsp_core_t;

    // Size in bytes minus one; doubles as the low-address alignment mask
    function automatic logic [OFF_W-1:0] size_minus1(acc_size_e s);
        logic [OFF_W-1:0] r;
        case (s)
            SZ_BYTE: r = OFF_W'(0);
            SZ_HALF: r = OFF_W'(1);
            SZ_WORD: r = OFF_W'(3);
            default: r = OFF_W'(7);
        endcase
        return r;
    endfunction

    // Byte enables for an access starting at lane 0
    function automatic logic [LANES-1:0] base_enables(acc_size_e s);
        logic [LANES-1:0] r;
        case (s)
            SZ_BYTE: r = LANES'(8'h01);
            SZ_HALF: r = LANES'(8'h03);
            SZ_WORD: r = LANES'(8'h0F);
            default: r = LANES'(8'hFF);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_noext
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    assign ea = base + disp_ext;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_pkg::*;
(
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);
    assign misaligned = |(off & size_minus1(size));
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
    import lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              big_endian,
    input  logic              sign_ext,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_lanes,
    output logic [DATA_W-1:0] ldata
);
    logic [OFF_W-1:0]  nm1;
    logic [OFF_W-1:0]  start_lane;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep_mask;
    logic              top_bit;

    assign nm1 = size_minus1(size);

    // Lowest lane touched. Big-endian mirrors the offset about the doubleword,
    // so register byte i then sits on lane start_lane+i in both orderings.
    assign start_lane = big_endian ? (~off - nm1) : off;

    assign be = base_enables(size) << start_lane;

    // Store operand copied to every slot of its size
    always_comb begin
        case (size)
            SZ_BYTE: wdata_lanes = {LANES{wdata[7:0]}};
            SZ_HALF: wdata_lanes = {(LANES/2){wdata[15:0]}};
            SZ_WORD: wdata_lanes = {(LANES/4){wdata[31:0]}};
            default: wdata_lanes = wdata;
        endcase
    end

    // Load: shift selected lanes down, mask, then extend
    assign shifted = rdata >> {start_lane, 3'b000};

    always_comb begin
        case (size)
            SZ_BYTE: keep_mask = DATA_W'(64'h0000_0000_0000_00FF);
            SZ_HALF: keep_mask = DATA_W'(64'h0000_0000_0000_FFFF);
            SZ_WORD: keep_mask = DATA_W'(64'h0000_0000_FFFF_FFFF);
            default: keep_mask = {DATA_W{1'b1}};
        endcase
        top_bit = shifted[{nm1, 3'b111}];
        ldata   = shifted & keep_mask;
        if (sign_ext && top_bit) begin
            ldata = ldata | ~keep_mask;
        end
    end
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              req_big_endian,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [63:0]       req_wdata,
    input  logic [63:0]       mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_be,
    output logic [63:0]       mem_wdata,
    output logic              rsp_valid,
    output logic              rsp_trap,
    output logic              rsp_wen,
    output logic [63:0]       rsp_data,
    output logic [ADDR_W-1:0] rsp_fault_addr
);
    acc_size_e         size;
    logic [ADDR_W-1:0] ea;
    logic              misaligned;
    logic [LANES-1:0]  be_raw;
    logic [DATA_W-1:0] ldata;
    logic              go;
    rsp_core_t         rsp_d, rsp_q;
    logic [ADDR_W-1:0] fault_d, fault_q;

    assign size = acc_size_e'(req_size);

    lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
        .base (req_base),
        .disp (req_disp),
        .ea   (ea)
    );

    lsu_align_chk u_chk_align (
        .size       (size),
        .off        (ea[OFF_W-1:0]),
        .misaligned (misaligned)
    );

    lsu_lane_steer u_steer (
        .size        (size),
        .off         (ea[OFF_W-1:0]),
        .big_endian  (req_big_endian),
        .sign_ext    (req_signed),
        .rdata       (mem_rdata),
        .wdata       (req_wdata),
        .be          (be_raw),
        .wdata_lanes (mem_wdata),
        .ldata       (ldata)
    );

    assign go       = req_valid && !misaligned;
    assign mem_en   = go;
    assign mem_we   = go && req_store;
    assign mem_be   = go ? be_raw : '0;
    assign mem_addr = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.trap  = req_valid && misaligned;
        rsp_d.wen   = go && !req_store;
        rsp_d.data  = (go && !req_store) ? ldata : '0;
        fault_d     = (req_valid && misaligned) ? ea : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q   <= '0;
            fault_q <= '0;
        end else begin
            rsp_q   <= rsp_d;
            fault_q <= fault_d;
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_trap       = rsp_q.trap;
    assign rsp_wen        = rsp_q.wen;
    assign rsp_data       = rsp_q.data;
    assign rsp_fault_addr = fault_q;
endmodule

// File: rtl/lsu_align_top_chk.sv
module lsu_align_top_chk #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_base,
    input logic [DISP_W-1:0] req_disp,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_be,
    input logic              rsp_valid,
    input logic              rsp_trap,
    input logic              rsp_wen,
    input logic [ADDR_W-1:0] rsp_fault_addr
);
    logic [ADDR_W-1:0] sum_c;
    logic              bad_c;
    logic [3:0]        nbytes_c;

    assign sum_c    = req_base + ADDR_W'($signed(req_disp));
    assign nbytes_c = 4'd1 << req_size;
    assign bad_c    = (sum_c[2:0] & (nbytes_c[2:0] - 3'd1)) != 3'd0;

    p_addr_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> mem_addr == {sum_c[ADDR_W-1:3], 3'b000});

    p_byte_no_trap_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd0) |=> !rsp_trap);

    p_quiet_bus_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && bad_c) |-> (mem_be == 8'h00 && !mem_we));

    p_fault_report_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && bad_c) |=> (rsp_trap && !rsp_wen && rsp_fault_addr == $past(sum_c)));

    p_store_enables_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_store && !bad_c) |-> ($countones(mem_be) == int'(nbytes_c)));

    p_rsp_delay_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rsp_valid == $past(req_valid));
endmodule

bind lsu_align_top lsu_align_top_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_props (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_store      (req_store),
    .req_size       (req_size),
    .req_base       (req_base),
    .req_disp       (req_disp),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_be         (mem_be),
    .rsp_valid      (rsp_valid),
    .rsp_trap       (rsp_trap),
    .rsp_wen        (rsp_wen),
    .rsp_fault_addr (rsp_fault_addr)
);

// File: tb/lsu_align_top_tb.sv
module lsu_align_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store, req_signed, req_big_endian;
    logic [1:0]  req_size;
    logic [31:0] req_base;
    logic [15:0] req_disp;
    logic [63:0] req_wdata, mem_rdata;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        rsp_valid, rsp_trap, rsp_wen;
    logic [63:0] rsp_data;
    logic [31:0] rsp_fault_addr;

    int checks = 0;
    int errors = 0;

    // expectations for the pending response
    logic        e_trap, e_wen;
    logic [63:0] e_data;
    logic [31:0] e_fault;
    string       e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_align_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .req_big_endian(req_big_endian),
        .req_base(req_base), .req_disp(req_disp), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
        .rsp_trap(rsp_trap), .rsp_wen(rsp_wen), .rsp_data(rsp_data),
        .rsp_fault_addr(rsp_fault_addr)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at the current negedge and check the memory side
    task automatic issue(input logic st, input logic [1:0] sz, input logic sg, input logic big,
                         input logic [31:0] base, input logic [15:0] disp,
                         input logic [63:0] wd, input logic [63:0] rd, input string tag);
        logic [31:0] ea;
        int          n;
        logic        bad;
        logic [7:0]  xbe;
        logic [63:0] ld;
        ea  = base + {{16{disp[15]}}, disp};
        n   = 1 << sz;
        bad = (int'(ea[2:0]) % n) != 0;
        xbe = '0;
        ld  = '0;
        for (int i = 0; i < n; i++) begin
            int a;
            int lane;
            int rb;
            a    = int'(ea[2:0]) + i;
            lane = big ? 7 - a : a;
            rb   = big ? n - 1 - i : i;
            if (!bad) xbe[lane] = 1'b1;
            ld[8*rb +: 8] = rd[8*lane +: 8];
        end
        if (sg && ld[8*n-1]) for (int b = 8*n; b < 64; b++) ld[b] = 1'b1;
        req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
        req_big_endian = big; req_base = base; req_disp = disp;
        req_wdata = wd; mem_rdata = rd;
        #1;
        chk(mem_addr == {ea[31:3], 3'b000}, {tag, " R1 mem_addr"}, 64'(mem_addr), 64'({ea[31:3], 3'b000}));
        chk(mem_be == xbe, {tag, (big ? " R5" : " R4"), " R3 mem_be"}, 64'(mem_be), 64'(xbe));
        chk(mem_we == (st && !bad), {tag, " R7 mem_we"}, 64'(mem_we), 64'(st && !bad));
        chk(mem_en == !bad, {tag, " R3 mem_en"}, 64'(mem_en), 64'(!bad));
        if (st && !bad) begin
            for (int i = 0; i < n; i++) begin
                int a;
                int lane;
                int rb;
                a    = int'(ea[2:0]) + i;
                lane = big ? 7 - a : a;
                rb   = big ? n - 1 - i : i;
                chk(mem_wdata[8*lane +: 8] == wd[8*rb +: 8], {tag, " R7 store lane"},
                    64'(mem_wdata[8*lane +: 8]), 64'(wd[8*rb +: 8]));
            end
        end
        e_trap  = bad;
        e_wen   = !st && !bad;
        e_data  = (!st && !bad) ? ld : 64'h0;
        e_fault = bad ? ea : 32'h0;
        e_tag   = tag;
    endtask

    // Wait one clock and check the registered response
    task automatic collect();
        @(negedge clk);
        chk(rsp_valid == 1'b1, {e_tag, " R8 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_trap == e_trap, {e_tag, " R2 rsp_trap"}, 64'(rsp_trap), 64'(e_trap));
        chk(rsp_wen == e_wen, {e_tag, " R6 rsp_wen"}, 64'(rsp_wen), 64'(e_wen));
        chk(rsp_data == e_data, {e_tag, " R6 rsp_data"}, rsp_data, e_data);
        chk(rsp_fault_addr == e_fault, {e_tag, " R3 fault"}, 64'(rsp_fault_addr), 64'(e_fault));
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 idle rsp_valid", 64'(rsp_valid), 64'd0);
    endtask

    localparam logic [63:0] RD = 64'hF1E2_D3C4_B5A6_9788;

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(rsp_trap == 1'b0, "R9 reset rsp_trap", 64'(rsp_trap), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_le_loads();
        issue(0, 2'd0, 1, 0, 32'h1000, 16'h0003, 0, RD, "R4 R6 LE byte signed"); collect();
        issue(0, 2'd0, 0, 0, 32'h1000, 16'h0007, 0, RD, "R4 R6 LE byte unsigned"); collect();
        issue(0, 2'd1, 1, 0, 32'h1000, 16'h0002, 0, RD, "R4 R6 LE half signed"); collect();
        issue(0, 2'd2, 1, 0, 32'h1000, 16'h0004, 0, RD, "R4 R6 LE word signed"); collect();
        issue(0, 2'd2, 0, 0, 32'h1000, 16'h0000, 0, RD, "R4 R6 LE word unsigned"); collect();
        issue(0, 2'd3, 1, 0, 32'h1000, 16'h0008, 0, RD, "R4 R6 LE dword"); collect();
        idle();
    endtask

    task automatic t_be_loads();
        issue(0, 2'd0, 1, 1, 32'h2000, 16'h0000, 0, RD, "R5 BE byte"); collect();
        issue(0, 2'd1, 0, 1, 32'h2000, 16'h0006, 0, RD, "R5 BE half"); collect();
        issue(0, 2'd2, 1, 1, 32'h2000, 16'h0004, 0, RD, "R5 BE word"); collect();
        issue(0, 2'd3, 0, 1, 32'h2000, 16'h0000, 0, RD, "R5 BE dword"); collect();
        idle();
    endtask

    task automatic t_stores();
        issue(1, 2'd0, 0, 0, 32'h3000, 16'h0005, 64'h1122_3344_5566_77A5, RD, "R7 LE byte st"); collect();
        issue(1, 2'd1, 0, 1, 32'h3000, 16'h0002, 64'h1122_3344_5566_BEEF, RD, "R7 BE half st"); collect();
        issue(1, 2'd2, 0, 0, 32'h3000, 16'h0004, 64'h1122_3344_DEAD_C0DE, RD, "R7 LE word st"); collect();
        issue(1, 2'd2, 0, 1, 32'h3000, 16'h0004, 64'h1122_3344_DEAD_C0DE, RD, "R7 BE word st"); collect();
        issue(1, 2'd3, 0, 1, 32'h3000, 16'h0000, 64'h0123_4567_89AB_CDEF, RD, "R7 BE dword st"); collect();
        idle();
    endtask

    task automatic t_misaligned();
        // negative displacement lands on misaligned addresses
        issue(0, 2'd1, 1, 0, 32'h4000, 16'hFFFF, 0, RD, "R2 R3 half odd"); collect();
        issue(1, 2'd2, 0, 1, 32'h4000, 16'hFFFE, 64'hFFFF, RD, "R2 R3 word off2"); collect();
        issue(0, 2'd3, 0, 1, 32'h4000, 16'hFFFC, 0, RD, "R2 R3 dword off4"); collect();
        issue(1, 2'd3, 0, 0, 32'h4001, 16'h0000, 64'h1, RD, "R2 R3 dword off1"); collect();
        issue(0, 2'd0, 0, 0, 32'h4000, 16'hFFFF, 0, RD, "R2 byte never traps"); collect();
        issue(0, 2'd2, 0, 0, 32'h4000, 16'h8000, 0, RD, "R1 disp min"); collect();
        idle();
    endtask

    task automatic t_endian_switch();
        issue(0, 2'd1, 0, 0, 32'h5000, 16'h0000, 0, RD, "R10 first LE"); collect();
        issue(0, 2'd1, 0, 1, 32'h5000, 16'h0000, 0, RD, "R10 then BE"); collect();
        issue(1, 2'd0, 0, 0, 32'h5000, 16'h0001, 64'h5A, RD, "R10 back to LE"); collect();
        idle();
    endtask

    task automatic t_reset_after_trap();
        issue(0, 2'd2, 0, 0, 32'h6000, 16'h0001, 0, RD, "R9 trap before reset");
        rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_trap == 1'b0, "R9 trap cleared", 64'(rsp_trap), 64'd0);
        chk(rsp_fault_addr == 32'h0, "R9 fault cleared", 64'(rsp_fault_addr), 64'd0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        req_valid = 0; req_store = 0; req_size = 0; req_signed = 0; req_big_endian = 0;
        req_base = 0; req_disp = 0; req_wdata = 0; mem_rdata = 0;
        @(negedge clk);
        t_reset();
        t_le_loads();
        t_be_loads();
        t_stores();
        t_misaligned();
        t_endian_switch();
        t_reset_after_trap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule